// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block produces the memory addresses for a small DMA engine with four independent channels. Each channel holds a 16-bit current address, a 16-bit remaining-transfer count, a step direction (up or down), a transfer kind (memory read or memory write), an 8-bit page value and a completion flag. A requester, usually a peripheral data path moving one byte at a time, names a channel and the kind of transfer it wants to make. One clock later it receives either a 24-bit physical address or a refusal. On a refusal the address bus carries all ones on its full 32 bits.

Software or a setup engine loads a channel through a programming port in a single cycle. A load writes the start address, count, kind, step direction and page, and it re-arms the channel. Every accepted request consumes one unit of count and moves the address by one byte. The page value never changes, so a transfer that runs off either end of its 64 KiB window wraps around inside that same window. On the access that exhausts the count, a one-cycle terminal-count strobe fires for that channel.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, every channel is in the completed state, so any request to it is refused. After reset `rsp_valid` is 0, `tc_pulse` is all zeros and `req_ready` is 1.
- R2: `req_ready` is the inverse of `prog_valid`, so programming has priority over requests. A request is accepted when `req_valid` and `req_ready` are both high. Exactly one clock after an accepted request, `rsp_valid` is 1. In every other cycle `rsp_valid` is 0.
- R3: A request to a channel whose completion flag is set is refused: `rsp_ok`=0 and `rsp_addr`=32'hFFFF_FFFF. The channel's address and count do not change.
- R4: A request whose kind (`req_is_write`: 1 = write, 0 = read) differs from the channel's programmed kind (`prog_is_write`) is refused in the same way as in R3. Such a request leaves the channel's address and count unchanged.
- R5: On an accepted request, `rsp_ok`=1 and `rsp_addr` = {8'h00, page[7:0], address[15:0]}. The address used is the channel's value from before that access.
- R6: After each granted access, the address moves by +1 when `prog_decr`=0 and by -1 when `prog_decr`=1, modulo 2^16. The page is never changed by this step.
- R7: Each granted access lowers the count by one. A channel programmed with count N is granted exactly N+1 accesses and then refuses. A count of 0 therefore allows one access.
- R8: `tc_pulse[c]` is high for exactly one cycle, in the same cycle as the response to the access that completes channel c. At most one bit of `tc_pulse` is set at a time.
- R9: A load (`prog_valid`=1) writes all fields of channel `prog_chan` and clears its completion flag. The other channels are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_valid | input | 1 | Load the channel named by prog_chan this cycle |
| prog_chan | input | 2 | Channel to load |
| prog_addr | input | 16 | Start address |
| prog_count | input | 16 | Transfers minus one |
| prog_is_write | input | 1 | Channel kind: 1 write, 0 read |
| prog_decr | input | 1 | 1 = address steps down |
| prog_page | input | 8 | Page value, address bits 23:16 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_chan | input | 2 | Requested channel |
| req_is_write | input | 1 | Requested kind: 1 write, 0 read |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | 1 = address granted, 0 = refused |
| rsp_addr | output | 32 | Physical address, or all ones when refused |
| tc_pulse | output | 4 | One-cycle terminal-count strobe per channel |

## Verification
The hardest situations to reach are the wrap of the 16-bit address inside an unchanged page and the exact access on which the count passes through zero. Both need a channel loaded with a start address next to 0x0000 or 0xFFFF and a small count, followed by an unbroken run of matching requests. The directed part of the stimulus loads such channels in both step directions and runs them to completion and past it. A long random phase then mixes loads, which carry small counts so that completions happen often, with requests of both kinds and with load/request collisions. A behavioural reference model checks every response and strobe in this phase.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } step_e;
  typedef enum logic { KIND_READ = 1'b0, KIND_WRITE = 1'b1 } kind_e;
endpackage

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    ld_addr,
  input  logic [CW-1:0]    ld_count,
  input  kind_e            ld_kind,
  input  step_e            ld_step,
  input  logic [PW-1:0]    ld_page,
  input  logic             hit,
  input  kind_e            req_kind,
  output logic             grant,
  output logic [PW+AW-1:0] phys,
  output logic             tc_pulse
);
  localparam int PHW = PW + AW;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input step_e s);
    return (s == DIR_DOWN) ? a - AW'(1) : a + AW'(1);
  endfunction

  function automatic logic [PHW-1:0] join_phys(input logic [PW-1:0] p, input logic [AW-1:0] a);
    return {p, a};
  endfunction

  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cnt_q;
  kind_e         kind_q;
  step_e         step_q;
  logic [PW-1:0] page_q;
  logic          done_q;
  logic          tc_q;

  // internal events brought out for checking
  logic kind_match;
  logic last_beat;

  assign kind_match = (req_kind == kind_q);
  assign grant      = hit && !done_q && kind_match;
  assign last_beat  = (cnt_q == '0);
  assign phys       = join_phys(page_q, cur_addr);
  assign tc_pulse   = tc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cnt_q    <= '0;
      kind_q   <= KIND_READ;
      step_q   <= DIR_UP;
      page_q   <= '0;
      done_q   <= 1'b1;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (load) begin
        cur_addr <= ld_addr;
        cnt_q    <= ld_count;
        kind_q   <= ld_kind;
        step_q   <= ld_step;
        page_q   <= ld_page;
        done_q   <= 1'b0;
      end else if (grant) begin
        cur_addr <= next_addr(cur_addr, step_q);
        cnt_q    <= cnt_q - CW'(1);
        if (last_beat) begin
          done_q <= 1'b1;
          tc_q   <= 1'b1;
        end
      end
    end
  end

  assert_refused_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && done_q && !load) |=> ($stable(cur_addr) && $stable(cnt_q) && done_q));

  assert_mismatch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !done_q && !kind_match && !load) |=> ($stable(cur_addr) && $stable(cnt_q)));

  assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !load && step_q == DIR_UP) |=> (cur_addr == $past(cur_addr) + AW'(1) && $stable(page_q)));

  assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !load && step_q == DIR_DOWN) |=> (cur_addr == $past(cur_addr) - AW'(1) && $stable(page_q)));

  assert_count_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !load) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_tc_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !load && last_beat) |=> (tc_q && done_q));

  assert_tc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);

  assert_load_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!done_q && cur_addr == $past(ld_addr) && cnt_q == $past(ld_count)));
endmodule

// File: rtl/dma_seq_resp.sv
module dma_seq_resp #(
  parameter int PHW = 24,
  parameter int RW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic           granted,
  input  logic [PHW-1:0] phys,
  output logic           rsp_valid,
  output logic           rsp_ok,
  output logic [RW-1:0]  rsp_addr
);
  localparam int PADW = RW - PHW;

  function automatic logic [RW-1:0] widen(input logic [PHW-1:0] p);
    return {{PADW{1'b0}}, p};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_addr  <= '1;
    end else begin
      rsp_valid <= fire;
      rsp_ok    <= fire && granted;
      rsp_addr  <= (fire && granted) ? widen(phys) : '1;
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);

  assert_refusal_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_addr == '1));

  assert_ok_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && granted) |=> (rsp_ok && rsp_addr[PHW-1:0] == $past(phys)));
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int PW  = 8,
  parameter int RW  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_valid,
  input  logic [$clog2(NCH)-1:0] prog_chan,
  input  logic [AW-1:0]          prog_addr,
  input  logic [CW-1:0]          prog_count,
  input  logic                   prog_is_write,
  input  logic                   prog_decr,
  input  logic [PW-1:0]          prog_page,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [$clog2(NCH)-1:0] req_chan,
  input  logic                   req_is_write,
  output logic                   rsp_valid,
  output logic                   rsp_ok,
  output logic [RW-1:0]          rsp_addr,
  output logic [NCH-1:0]         tc_pulse
);
  localparam int PHW = PW + AW;

  logic                 fire;
  logic [NCH-1:0]       grants;
  logic [PHW-1:0]       phys_all [NCH];
  logic                 granted;
  kind_e                ld_kind, rq_kind;
  step_e                ld_step;

  assign req_ready = !prog_valid;
  assign fire      = req_valid && req_ready;
  assign granted   = |grants;
  assign ld_kind   = prog_is_write ? KIND_WRITE : KIND_READ;
  assign rq_kind   = req_is_write ? KIND_WRITE : KIND_READ;
  assign ld_step   = prog_decr ? DIR_DOWN : DIR_UP;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_seq_chan #(.AW(AW), .CW(CW), .PW(PW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (prog_valid && prog_chan == c),
      .ld_addr  (prog_addr),
      .ld_count (prog_count),
      .ld_kind  (ld_kind),
      .ld_step  (ld_step),
      .ld_page  (prog_page),
      .hit      (fire && req_chan == c),
      .req_kind (rq_kind),
      .grant    (grants[c]),
      .phys     (phys_all[c]),
      .tc_pulse (tc_pulse[c])
    );
  end

  dma_seq_resp #(.PHW(PHW), .RW(RW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .granted   (granted),
    .phys      (phys_all[req_chan]),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_addr  (rsp_addr)
  );

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grants));

  assert_tc_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_pulse));

  assert_tc_with_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_pulse) |-> (rsp_valid && rsp_ok));
endmodule

// File: tb/dma_addr_seq_test.sv
module dma_addr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_valid = 1'b0;
  logic [1:0]  prog_chan = '0;
  logic [15:0] prog_addr = '0;
  logic [15:0] prog_count = '0;
  logic        prog_is_write = 1'b0;
  logic        prog_decr = 1'b0;
  logic [7:0]  prog_page = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_chan = '0;
  logic        req_is_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ok;
  logic [31:0] rsp_addr;
  logic [3:0]  tc_pulse;

  int checks = 0;
  int errors = 0;

  // reference model state
  int    m_addr [NCH];
  int    m_cnt  [NCH];
  int    m_page [NCH];
  bit    m_wr   [NCH];
  bit    m_dn   [NCH];
  bit    m_done [NCH];
  bit    e_rv;
  bit    e_ok;
  logic [31:0] e_addr;
  bit    e_tc [NCH];
  string e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_seq uut (
    .clk(clk), .rst_n(rst_n),
    .prog_valid(prog_valid), .prog_chan(prog_chan), .prog_addr(prog_addr),
    .prog_count(prog_count), .prog_is_write(prog_is_write), .prog_decr(prog_decr),
    .prog_page(prog_page),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_is_write(req_is_write),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr), .tc_pulse(tc_pulse)
  );

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_addr[c] = 0; m_cnt[c] = 0; m_page[c] = 0;
      m_wr[c] = 0; m_dn[c] = 0; m_done[c] = 1; e_tc[c] = 0;
    end
    e_rv = 0; e_ok = 0; e_addr = '1; e_tag = "R1";
  endtask

  task automatic compare();
    chk(rsp_valid == e_rv, "R2", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
    if (e_rv) begin
      chk(rsp_ok == e_ok, e_tag, "rsp_ok", 32'(rsp_ok), 32'(e_ok));
      chk(rsp_addr == e_addr, e_tag, "rsp_addr", rsp_addr, e_addr);
    end
    for (int c = 0; c < NCH; c++)
      chk(tc_pulse[c] == e_tc[c], "R8", "tc_pulse", 32'(tc_pulse), 32'(c));
  endtask

  task automatic model_step(input bit pv, input int pch, input int pa, input int pc,
                            input bit pw, input bit pd, input int pp,
                            input bit rv, input int rch, input bit rw);
    bit fire;
    fire = rv && !pv;
    for (int c = 0; c < NCH; c++) e_tc[c] = 0;
    e_rv = fire; e_ok = 0; e_addr = '1;
    if (pv) begin
      m_addr[pch] = pa; m_cnt[pch] = pc; m_wr[pch] = pw; m_dn[pch] = pd;
      m_page[pch] = pp; m_done[pch] = 0;
    end
    if (fire) begin
      if (m_done[rch]) e_tag = "R3";
      else if (rw != m_wr[rch]) e_tag = "R4";
      else begin
        e_tag = "R5";
        e_ok = 1;
        e_addr = 32'((m_page[rch] << 16) | m_addr[rch]);
        m_addr[rch] = (m_addr[rch] + (m_dn[rch] ? -1 : 1)) & 16'hFFFF;
        if (m_cnt[rch] == 0) begin
          m_cnt[rch] = 16'hFFFF; m_done[rch] = 1; e_tc[rch] = 1;
        end else m_cnt[rch] = m_cnt[rch] - 1;
      end
    end
  endtask

  task automatic step(input bit pv, input int pch, input int pa, input int pc,
                      input bit pw, input bit pd, input int pp,
                      input bit rv, input int rch, input bit rw);
    @(negedge clk);
    compare();
    prog_valid = pv; prog_chan = 2'(pch); prog_addr = 16'(pa); prog_count = 16'(pc);
    prog_is_write = pw; prog_decr = pd; prog_page = 8'(pp);
    req_valid = rv; req_chan = 2'(rch); req_is_write = rw;
    #1;
    chk(req_ready == !pv, "R2", "req_ready", 32'(req_ready), 32'(!pv));
    model_step(pv, pch, pa, pc, pw, pd, pp, rv, rch, rw);
  endtask

  task automatic load(input int ch, input int a, input int n, input bit w, input bit d, input int p);
    step(1, ch, a, n, w, d, p, 0, 0, 0);
  endtask

  task automatic req(input int ch, input bit w);
    step(0, 0, 0, 0, 0, 0, 0, 1, ch, w);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk(tc_pulse == 4'b0, "R1", "tc_pulse after reset", 32'(tc_pulse), 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);
    // R1/R3: unprogrammed channels refuse
    for (int c = 0; c < NCH; c++) req(c, c[0]);
    idle();

    // R5/R6/R7/R8: write channel counting up, three accesses
    load(0, 16'h1234, 2, 1, 0, 8'h0A);
    req(0, 1); req(0, 1); req(0, 1);
    req(0, 1);                       // R3 after completion
    idle();

    // R4/R6: read channel counting down across 0x0000 inside its page
    load(1, 16'h0001, 5, 0, 1, 8'h3C);
    req(1, 0); req(1, 1);            // R4 mismatch leaves state
    req(1, 0); req(1, 0); idle();

    // R6: upward wrap from 0xFFFF stays in page
    load(3, 16'hFFFE, 3, 0, 0, 8'hFF);
    req(3, 0); req(3, 0); req(3, 0); req(3, 0); req(3, 0);

    // R7: count of zero gives a single access
    load(2, 16'h8000, 0, 1, 0, 8'h01);
    req(2, 1); req(2, 1); idle();

    // R2: collision, load wins and request is not taken
    step(1, 2, 16'h0100, 1, 1, 0, 8'h22, 1, 1, 0);
    idle();
    // R9: reload re-arms and other channels untouched
    req(2, 1); req(1, 0); req(2, 1); req(2, 1); idle();

    // random phase checked against the model on every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 15));
      step(r == 0, int'($urandom_range(0, 3)), int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 6)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, 255)),
           r < 12, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
    end
    idle(); idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule